// File: doc/BRIEF.md
# Double-Buffered Serial Peripheral Master

This block is a master-only, full-duplex, three-wire synchronous serial engine. It drives a serial clock, drives a data output and captures a data input. For each byte it shifts out it captures one byte from the data input. A 12-bit divisor sets the serial clock rate. Two inputs select one of the four clock polarity/phase modes, and a third selects the bit order, which applies to both directions.

The host writes a byte into a one-deep transmit queue with a single-cycle strobe. The engine moves the queued byte into its shifter as soon as the shifter is free and transmission is enabled. A second byte can therefore be queued while the first one is still shifting, and the two leave back to back with no idle half-period between them. Each received byte is placed in a receive holding register and flagged until the host acknowledges it with a read strobe. Three flags show the state: queue empty, all transmission finished, and received byte waiting.

Top module: `spi_master_engine`

## Requirements
- R1: Reset (synchronous, active low) sets txbuf_empty to 1 and tx_done to 0, sets rx_ready to 0, and leaves sck at the cpol level.
- R2: With divisor N (0 to 4095), each sck level within a transfer lasts exactly N+1 clock cycles, so one byte takes 16(N+1) cycles. From a write strobe sampled at edge W, the first byte is loaded at edge W+1 and ends at edge W+1+16(N+1) for a single byte, or at W+1+32(N+1) for two queued bytes.
- R3: While no transfer is active, sck rests at the cpol level. The leading edge of each bit is the transition away from that level.
- R4: With cpha=0, the first bit is on mosi from the load cycle onward, before the first sck edge. miso is sampled on leading edges and mosi changes on trailing edges. With cpha=1, mosi changes on leading edges and miso is sampled on trailing edges.
- R5: With lsb_first=1, bit 0 goes out first and the first captured bit goes into bit 0. With lsb_first=0, bit 7 is first in both directions.
- R6: txbuf_empty falls the cycle after a write strobe and rises when the queued byte moves into the shifter. A byte queued during a transfer starts on the same edge that ends the previous byte, with no gap.
- R7: tx_done is set when a byte ends and no byte is ready to follow. It is cleared when the next byte is loaded.
- R8: When a byte ends with rx_en=1, rd_data takes the captured byte and rx_ready is set on that same edge. rx_ready then stays set until rd_strobe is sampled high.
- R9: With rx_en=0, a finished byte raises no rx_ready and leaves rd_data unchanged.
- R10: With tx_en=0, a queued byte is not started and sck does not toggle. Once tx_en is high, the byte is loaded on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Allows the queued byte to start |
| rx_en | input | 1 | Allows captured bytes to reach the receive register |
| cpol | input | 1 | Idle level of sck |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| lsb_first | input | 1 | 1: bit 0 first, 0: bit 7 first |
| divisor | input | 12 | Half-period length minus one, in clock cycles |
| wr_valid | input | 1 | Write strobe for the transmit queue |
| wr_data | input | 8 | Byte to queue |
| rd_strobe | input | 1 | Acknowledges the received byte |
| rd_data | output | 8 | Last received byte |
| txbuf_empty | output | 1 | Transmit queue can take a byte |
| tx_done | output | 1 | Shifter idle with nothing queued after a transfer |
| rx_ready | output | 1 | Received byte waiting |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The queue flag is due one cycle after the write strobe and rises again one cycle later, when the shifter loads. Every sck level is due N+1 cycles after the previous one, and tx_done is due 2+32(N+1) cycles after the write for a pair of bytes. The bench changes inputs on falling clock edges and counts falling edges from the write, so each flag, level and count is compared at the first falling edge after the rising edge that is due to produce it. A slave model in the bench watches sck at every falling edge. It records mosi on the sample edge of the selected mode and presents its next miso bit right after each setup edge, which gives every sample edge at least half a clock period of settled data.

// File: rtl/spim_pkg.sv
// spim_pkg: types shared by the serial master engine.
// Assumes nothing beyond IEEE 1800-2017 packages.
package spim_pkg;

    // Shifter activity.
    typedef enum logic {
        XF_IDLE  = 1'b0,
        XF_SHIFT = 1'b1
    } xfer_state_t;

    // Line configuration, grouped so the core takes it as one input.
    typedef struct packed {
        logic cpol;
        logic cpha;
        logic lsb_first;
    } line_cfg_t;

endpackage

// File: rtl/spim_baud_gen.sv
// spim_baud_gen: produces one tick every (divisor+1) cycles while run is high.
// Each tick marks one serial clock half-period. The counter is held at zero
// while idle, so the first tick comes divisor+1 cycles after run rises.
// Assumes divisor is kept stable during a transfer.
module spim_baud_gen #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    // Tick when the half-period count reaches the divisor.
    always_comb tick = run && (cnt_q == divisor);

    // Count cycles within a half-period; restart on tick or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: a tick is always followed by a restarted count.
    assert_restart_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));

endmodule

// File: rtl/spim_tx_queue.sv
// spim_tx_queue: one-entry transmit holding register.
// A write strobe fills it. A take from the shifter empties it. A write in the
// same cycle as a take keeps it full with the new byte, and the shifter
// gets the old one. Assumes the host writes only when it wants to replace
// or fill the entry.
module spim_tx_queue #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] q_data
);

    // Hold the queued byte and its occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full   <= 1'b0;
            q_data <= '0;
        end else if (wr_en) begin
            full   <= 1'b1;
            q_data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // R6: the shifter takes only an occupied entry.
    assert_take_needs_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full);

    // R6: a take with no write leaves the entry empty.
    assert_empty_after_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_en) |=> !full);

endmodule

// File: rtl/spim_shift_core.sv
// spim_shift_core: transfer control for one byte at a time.
// Counts 2*DATA_W serial half-periods per byte, drives sck and mosi, samples
// miso on the edge selected by cpha, and reports the completed receive byte.
// Loads the next queued byte on the final half-period tick, so bytes follow
// each other without a gap. Assumes DATA_W is a power of two and that
// cfg is changed only while idle.
module spim_shift_core
    import spim_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  line_cfg_t         cfg,
    input  logic              q_full,
    input  logic [DATA_W-1:0] q_data,
    output logic              take,
    input  logic              tick,
    output logic              run,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              commit,
    output logic [DATA_W-1:0] commit_data,
    output logic              tx_done
);

    localparam int EDGES = 2 * DATA_W;
    localparam int ECW   = $clog2(EDGES);
    localparam int BW    = $clog2(DATA_W);

    xfer_state_t       state_q;
    logic [ECW-1:0]    edge_q;
    logic              sck_ph_q;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] rx_sr_q;
    logic [BW-1:0]     bit_k;
    logic              last_edge;
    logic              lead;
    logic              sample_now;
    logic              setup_now;

    // Map the transfer-order index to a physical bit position.
    function automatic logic [BW-1:0] phys(input logic [BW-1:0] k, input logic lsb);
        return lsb ? k : (BW'(DATA_W - 1) - k);
    endfunction

    // Decode the half-period counter into bit index and edge kind.
    always_comb begin
        bit_k      = edge_q[ECW-1:1];
        lead       = ~edge_q[0];
        last_edge  = (edge_q == ECW'(EDGES - 1));
        run        = (state_q == XF_SHIFT);
        sample_now = run && tick && (lead ^ cfg.cpha);
        setup_now  = run && tick && !(lead ^ cfg.cpha);
        take       = tx_en && q_full && (!run || (tick && last_edge));
        commit     = run && tick && last_edge;
        sck        = cfg.cpol ^ sck_ph_q;
    end

    // Sequence the byte: start on take, toggle sck phase on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= XF_IDLE;
            edge_q   <= '0;
            sck_ph_q <= 1'b0;
        end else if (take) begin
            state_q  <= XF_SHIFT;
            edge_q   <= '0;
            sck_ph_q <= 1'b0;
        end else if (run && tick) begin
            sck_ph_q <= ~sck_ph_q;
            edge_q   <= edge_q + 1'b1;
            if (last_edge) begin
                state_q <= XF_IDLE;
            end
        end
    end

    // Keep a copy of the byte being sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (take) begin
            hold_q <= q_data;
        end
    end

    // Drive mosi: preload for cpha=0, otherwise change on setup edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mosi <= 1'b0;
        end else if (take && !cfg.cpha) begin
            mosi <= q_data[phys('0, cfg.lsb_first)];
        end else if (setup_now) begin
            if (cfg.cpha) begin
                mosi <= hold_q[phys(bit_k, cfg.lsb_first)];
            end else if (!last_edge) begin
                mosi <= hold_q[phys(bit_k + 1'b1, cfg.lsb_first)];
            end
        end
    end

    // Capture miso on sample edges into its transfer-order position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sr_q <= '0;
        end else if (sample_now) begin
            rx_sr_q[phys(bit_k, cfg.lsb_first)] <= miso;
        end
    end

    // Completed byte; with cpha=1 the final sample lands on the last tick.
    always_comb begin
        commit_data = rx_sr_q;
        if (cfg.cpha) begin
            commit_data[phys(bit_k, cfg.lsb_first)] = miso;
        end
    end

    // Flag the end of transmission when nothing follows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_done <= 1'b0;
        end else if (take) begin
            tx_done <= 1'b0;
        end else if (commit) begin
            tx_done <= 1'b1;
        end
    end

    // R3: sck rests at the polarity level while idle.
    assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (sck == cfg.cpol));

    // R4: mosi holds across a sample edge.
    assert_mosi_steady_on_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_now && !take) |=> $stable(mosi));

    // R7: transmission is never reported finished while shifting.
    assert_done_only_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> !run);

    // R10: with transmit disabled an idle shifter stays idle.
    assert_tx_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !run) |=> !run);

endmodule

// File: rtl/spim_rx_buf.sv
// spim_rx_buf: receive holding register with a ready flag.
// Stores each committed byte when receive is enabled. The flag clears on a
// read strobe, and a commit in the same cycle wins.
// Assumes commits are at least two cycles apart.
module spim_rx_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              commit,
    input  logic [DATA_W-1:0] commit_data,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_ready
);

    // Latch received bytes and track whether the host has read them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rx_ready <= 1'b0;
        end else if (commit && rx_en) begin
            rd_data  <= commit_data;
            rx_ready <= 1'b1;
        end else if (rd_strobe) begin
            rx_ready <= 1'b0;
        end
    end

    // R8: the ready flag holds until read.
    assert_ready_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rd_strobe) |=> rx_ready);

    // R9: nothing becomes ready while receive is disabled.
    assert_rx_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !$rose(rx_ready));

endmodule

// File: rtl/spi_master_engine.sv
// spi_master_engine: full-duplex serial master with a queued transmit byte.
// Ties together the baud generator, the transmit queue, the shifter and the
// receive register. Assumes line configuration and divisor are changed only
// while no transfer is active.
module spi_master_engine
    import spim_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              txbuf_empty,
    output logic              tx_done,
    output logic              rx_ready,
    output logic              sck,
    output logic              mosi,
    input  logic              miso
);

    line_cfg_t         cfg;
    logic              tick;
    logic              run;
    logic              take;
    logic              q_full;
    logic [DATA_W-1:0] q_data;
    logic              commit;
    logic [DATA_W-1:0] commit_data;

    // Group the line settings.
    always_comb begin
        cfg.cpol      = cpol;
        cfg.cpha      = cpha;
        cfg.lsb_first = lsb_first;
        txbuf_empty   = !q_full;
    end

    spim_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .divisor (divisor),
        .tick    (tick)
    );

    spim_tx_queue #(.DATA_W(DATA_W)) u_txq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_valid),
        .wr_data (wr_data),
        .take    (take),
        .full    (q_full),
        .q_data  (q_data)
    );

    spim_shift_core #(.DATA_W(DATA_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .cfg         (cfg),
        .q_full      (q_full),
        .q_data      (q_data),
        .take        (take),
        .tick        (tick),
        .run         (run),
        .sck         (sck),
        .mosi        (mosi),
        .miso        (miso),
        .commit      (commit),
        .commit_data (commit_data),
        .tx_done     (tx_done)
    );

    spim_rx_buf #(.DATA_W(DATA_W)) u_rxb (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_en       (rx_en),
        .commit      (commit),
        .commit_data (commit_data),
        .rd_strobe   (rd_strobe),
        .rd_data     (rd_data),
        .rx_ready    (rx_ready)
    );

    // R1: reset leaves the queue empty.
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> txbuf_empty);

endmodule

// File: tb/test_spi_master_engine.sv
module test_spi_master_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0, rx_en = 1'b0, cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0;
    logic [11:0] divisor = '0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_strobe = 1'b0;
    logic [7:0]  rd_data;
    logic        txbuf_empty, tx_done, rx_ready, sck, mosi;
    logic        miso = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    spi_master_engine i_spi_master_engine (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .cpol(cpol),
        .cpha(cpha), .lsb_first(lsb_first), .divisor(divisor),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .txbuf_empty(txbuf_empty), .tx_done(tx_done),
        .rx_ready(rx_ready), .sck(sck), .mosi(mosi), .miso(miso)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int pos(input int k, input bit lsb);
        return lsb ? k : 7 - k;
    endfunction

    // Two queued bytes out, two slave bytes in; checks timing, order, flags.
    task automatic run_pair(input int mode, input bit lsb, input int n,
                            input logic [7:0] a, input logic [7:0] b,
                            input logic [7:0] sa, input logic [7:0] sb, input bit rxe);
        int cnt, gap, dix, mk, mi, ri, guard;
        logic prev, lead;
        logic [7:0] gm0, gm1, gs0, gs1, rd_before, cur;
        bit gap_bad;
        cpol = mode[1]; cpha = mode[0]; lsb_first = lsb; divisor = 12'(n);
        rx_en = rxe; tx_en = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(sck == cpol, "R3 idle sck", sck, cpol);
        rd_before = rd_data;
        miso = sa[pos(0, lsb)];
        dix = cpha ? 0 : 1;
        wr_valid = 1'b1; wr_data = a;
        @(negedge clk); wr_valid = 1'b0; cnt = 1;
        chk(txbuf_empty == 1'b0, "R6 empty falls", txbuf_empty, 0);
        @(negedge clk); cnt = 2;
        chk(txbuf_empty == 1'b1, "R6 empty rises on load", txbuf_empty, 1);
        if (!cpha) chk(mosi == a[pos(0, lsb)], "R4 first bit before edge", mosi, a[pos(0, lsb)]);
        wr_valid = 1'b1; wr_data = b;
        prev = sck; gap = 0; mk = 0; mi = 0; ri = 0; gap_bad = 0;
        gm0 = '0; gm1 = '0; gs0 = '0; gs1 = '0;
        for (guard = 0; guard < 20000; guard++) begin
            @(negedge clk);
            cnt++; gap++; wr_valid = 1'b0; rd_strobe = 1'b0;
            if (sck !== prev) begin
                if (gap != n + 1) gap_bad = 1;
                gap = 0;
                lead = (sck != cpol);
                if (lead ^ cpha) begin
                    if (mi == 0) gm0[pos(mk, lsb)] = mosi;
                    else if (mi == 1) gm1[pos(mk, lsb)] = mosi;
                    mk++;
                    if (mk == 8) begin mk = 0; mi++; end
                end else begin
                    if (dix < 16) begin
                        cur = (dix < 8) ? sa : sb;
                        miso = cur[pos(dix % 8, lsb)];
                    end
                    dix++;
                end
                prev = sck;
            end
            if (rx_ready) begin
                if (ri == 0) gs0 = rd_data; else if (ri == 1) gs1 = rd_data;
                ri++;
                rd_strobe = 1'b1;
            end
            if (tx_done) break;
        end
        @(negedge clk); rd_strobe = 1'b0;
        chk(cnt == 2 + 32 * (n + 1), "R2 pair duration", cnt, 2 + 32 * (n + 1));
        chk(!gap_bad, "R2 half-period length", gap_bad, 0);
        chk(gm0 == a, "R5 first byte order", gm0, a);
        chk(gm1 == b, "R6 back-to-back byte", gm1, b);
        chk(sck == cpol, "R3 sck idle after", sck, cpol);
        if (rxe) begin
            chk(ri == 2, "R8 two bytes ready", ri, 2);
            chk(gs0 == sa, "R8 rx byte 0", gs0, sa);
            chk(gs1 == sb, "R5 rx byte 1", gs1, sb);
        end else begin
            chk(ri == 0, "R9 no ready when disabled", ri, 0);
            chk(rd_data == rd_before, "R9 rd_data kept", rd_data, rd_before);
        end
    endtask

    initial begin
        int idx, cnt;
        bit bad;
        idx = 0;
        repeat (3) @(negedge clk);
        chk(txbuf_empty == 1'b1, "R1 empty in reset", txbuf_empty, 1);
        chk(tx_done == 1'b0, "R1 done clear", tx_done, 0);
        chk(rx_ready == 1'b0, "R1 ready clear", rx_ready, 0);
        chk(sck == cpol, "R1 sck level", sck, cpol);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txbuf_empty == 1'b1 && tx_done == 1'b0, "R1 after release", {txbuf_empty, tx_done}, 2);

        for (int m = 0; m < 4; m++) begin
            for (int l = 0; l < 2; l++) begin
                for (int d = 0; d < 3; d++) begin
                    run_pair(m, l[0], d * d + d * 2 - (d == 2 ? 3 : 0),
                             8'(idx * 37 + 5), 8'(idx * 101 + 66),
                             8'(idx * 91 + 13), 8'(~(idx * 23 + 7)), (idx % 5) != 3);
                    idx++;
                end
            end
        end

        // R10: transmit disabled holds the queued byte.
        cpol = 1'b0; cpha = 1'b0; lsb_first = 1'b0; divisor = 12'd1; rx_en = 1'b1;
        tx_en = 1'b0; miso = 1'b1;
        @(negedge clk);
        wr_valid = 1'b1; wr_data = 8'hA5;
        @(negedge clk); wr_valid = 1'b0;
        bad = 0;
        repeat (40) begin
            @(negedge clk);
            if (sck != cpol) bad = 1;
        end
        chk(!bad, "R10 sck quiet when disabled", bad, 0);
        chk(txbuf_empty == 1'b0, "R10 byte still queued", txbuf_empty, 0);
        tx_en = 1'b1; cnt = 0;
        for (int g = 0; g < 1000; g++) begin
            @(negedge clk); cnt++;
            if (tx_done) break;
        end
        chk(cnt == 1 + 16 * 2, "R10 start after enable", cnt, 33);
        repeat (5) @(negedge clk);
        chk(rx_ready == 1'b1, "R8 ready held", rx_ready, 1);
        chk(rd_data == 8'hFF, "R8 rd_data", rd_data, 8'hFF);
        rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
        chk(rx_ready == 1'b0, "R8 cleared by read", rx_ready, 0);

        // R2: largest divisor, single byte.
        cpol = 1'b1; cpha = 1'b1; lsb_first = 1'b1; divisor = 12'd4095; miso = 1'b0;
        @(negedge clk);
        wr_valid = 1'b1; wr_data = 8'h3C;
        @(negedge clk); wr_valid = 1'b0; cnt = 1;
        for (int g = 0; g < 70000; g++) begin
            @(negedge clk); cnt++;
            if (tx_done) break;
        end
        chk(cnt == 2 + 16 * 4096, "R2 max divisor byte", cnt, 2 + 16 * 4096);
        chk(rx_ready == 1'b1 && rd_data == 8'h00, "R8 max divisor rx", rd_data, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule